// File: doc/BRIEF.md
# Oscillator Tap and Fractional Modulation Tracker

This block keeps the digital control word of a tapped oscillator: a coarse tap code and a fractional modulation code. While frequency tracking is enabled, a comparator outside the block sends single-cycle raise and lower strobes. Each strobe moves the combined code by one fractional step. Moving past the top of the fractional range carries into the next tap with the fraction wrapping to zero. Moving below zero borrows from the tap below with the fraction wrapping to its maximum. The code saturates at both ends of the whole range. When tracking is disabled, the codes stay put and software can write them directly.

On every clock cycle, treated as one output slot, the block also emits a select. The select chooses between the base tap and the tap one above it. A phase accumulator adds the fractional code each slot, and a carry out of its top bit picks the higher tap. The upper tap therefore appears in exactly as many slots per frame as the fraction's value, spread across the frame. A carry at the top of the fraction always gives tap plus one with fraction zero. It never gives the faulty pairing of tap plus one with fraction one below maximum, which would push the output frequency sharply upward.

Top module: `dco_mod_tracker`

## Requirements
- R1: After reset the tap code is 0, the fraction code is 0 and the select output is 0.
- R2: With tracking enabled and only the raise strobe high, a fraction below its maximum (31 at the default 5-bit width) increments by one and the tap is unchanged on the next cycle.
- R3: With tracking enabled and only the raise strobe high, fraction 31 and tap below its maximum, the next cycle shows tap+1 and fraction 0. The pair (tap+1, fraction 30) never follows (tap, fraction 31).
- R4: With tracking enabled and only the lower strobe high, a nonzero fraction decrements by one. Fraction 0 with tap above 0 gives tap-1 and fraction 31.
- R5: A raise at tap 7 (default 3-bit width) with fraction 31, or a lower at tap 0 with fraction 0, leaves both codes unchanged.
- R6: With tracking enabled and both strobes high in the same cycle, neither code changes.
- R7: With tracking disabled, the raise and lower strobes have no effect on either code.
- R8: With tracking disabled, a load pulse places the load values into tap and fraction on the next cycle. With tracking enabled, a load pulse is ignored.
- R9: With the fraction held at value M, any 32 consecutive slots contain exactly M slots with the select high.
- R10: With the fraction held at 16, the select alternates between high and low from slot to slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one output slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| fll_en | input | 1 | Enables automatic tracking by the strobes |
| step_up | input | 1 | Raise request from the frequency comparator |
| step_dn | input | 1 | Lower request from the frequency comparator |
| load_en | input | 1 | Direct write of the codes, honoured only with tracking off |
| load_tap | input | TAP_W | Tap value for a direct write |
| load_frac | input | MOD_W | Fraction value for a direct write |
| tap_code | output | TAP_W | Current tap code |
| frac_code | output | MOD_W | Current fractional modulation code |
| hi_sel | output | 1 | 1 selects tap_code+1 for this slot, 0 selects tap_code |

## Verification
The bench builds the block with the defaults: a 3-bit tap and a 5-bit fraction. At this size, stepping from one end of the code range to the other takes 255 strobes, so both saturation corners are reached by walking through every tap boundary, and the wrap from 31 to 0 is crossed at each one. A 32-slot frame is short enough that the select count for several fractions, including 0, 1, 16 and 31, is checked over whole frames. A monitor watches every cycle for the forbidden change from fraction 31 to tap+1 with fraction 30.

// File: rtl/dco_mod_tracker.sv
module dco_mod_tracker #(
  parameter int TAP_W = 3,
  parameter int MOD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fll_en,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             load_en,
  input  logic [TAP_W-1:0] load_tap,
  input  logic [MOD_W-1:0] load_frac,
  output logic [TAP_W-1:0] tap_code,
  output logic [MOD_W-1:0] frac_code,
  output logic             hi_sel
);
  localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
  localparam logic [MOD_W-1:0] FRAC_MAX = {MOD_W{1'b1}};

  logic [TAP_W-1:0] tap_q, tap_d;
  logic [MOD_W-1:0] frac_q, frac_d, acc_q;
  logic [MOD_W:0]   acc_sum;

  wire raise = fll_en & step_up & ~step_dn;
  wire lower = fll_en & step_dn & ~step_up;

  always_comb begin
    tap_d  = tap_q;
    frac_d = frac_q;
    if (!fll_en) begin
      if (load_en) begin
        tap_d  = load_tap;
        frac_d = load_frac;
      end
    end else if (raise) begin
      if (frac_q != FRAC_MAX) begin
        frac_d = frac_q + 1'b1;
      end else if (tap_q != TAP_MAX) begin
        tap_d  = tap_q + 1'b1;
        frac_d = '0;
      end
    end else if (lower) begin
      if (frac_q != '0) begin
        frac_d = frac_q - 1'b1;
      end else if (tap_q != '0) begin
        tap_d  = tap_q - 1'b1;
        frac_d = FRAC_MAX;
      end
    end
  end

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= '0;
      frac_q <= '0;
      acc_q  <= '0;
    end else begin
      tap_q  <= tap_d;
      frac_q <= frac_d;
      acc_q  <= acc_sum[MOD_W-1:0];
    end
  end

  assign tap_code  = tap_q;
  assign frac_code = frac_q;
  assign hi_sel    = acc_sum[MOD_W];
endmodule

// File: rtl/dco_mod_tracker_chk.sv
module dco_mod_tracker_chk #(
  parameter int TAP_W = 3,
  parameter int MOD_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fll_en,
  input logic             step_up,
  input logic             step_dn,
  input logic             load_en,
  input logic [TAP_W-1:0] tap_code,
  input logic [MOD_W-1:0] frac_code
);
  localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
  localparam logic [MOD_W-1:0] FRAC_MAX = {MOD_W{1'b1}};

  AST_RAISE_IN_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    fll_en && step_up && !step_dn && frac_code != FRAC_MAX |=>
    frac_code == MOD_W'($past(frac_code) + 1'b1) && $stable(tap_code)); // R2

  AST_CLEAN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    fll_en && step_up && !step_dn && frac_code == FRAC_MAX && tap_code != TAP_MAX |=>
    tap_code == TAP_W'($past(tap_code) + 1'b1) && frac_code == '0); // R3

  AST_NO_BAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    frac_code == FRAC_MAX && fll_en |=>
    !(tap_code == TAP_W'($past(tap_code) + 1'b1) && frac_code == FRAC_MAX - 1'b1)); // R3

  AST_CLEAN_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    fll_en && step_dn && !step_up && frac_code == '0 && tap_code != '0 |=>
    tap_code == TAP_W'($past(tap_code) - 1'b1) && frac_code == FRAC_MAX); // R4

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    fll_en && step_up && !step_dn && frac_code == FRAC_MAX && tap_code == TAP_MAX |=>
    $stable(tap_code) && $stable(frac_code)); // R5

  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    fll_en && step_dn && !step_up && frac_code == '0 && tap_code == '0 |=>
    $stable(tap_code) && $stable(frac_code)); // R5

  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    fll_en && step_up && step_dn |=> $stable(tap_code) && $stable(frac_code)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fll_en && !load_en |=> $stable(tap_code) && $stable(frac_code)); // R7
endmodule

bind dco_mod_tracker dco_mod_tracker_chk #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fll_en(fll_en), .step_up(step_up), .step_dn(step_dn),
  .load_en(load_en), .tap_code(tap_code), .frac_code(frac_code)
);

// File: tb/test_dco_mod_tracker.sv
module test_dco_mod_tracker;
  localparam int PERIOD = 10;
  localparam int TAP_W = 3;
  localparam int MOD_W = 5;

  logic clk = 0, rst_n = 0, fll_en = 0, step_up = 0, step_dn = 0, load_en = 0;
  logic [TAP_W-1:0] load_tap = '0;
  logic [MOD_W-1:0] load_frac = '0;
  logic [TAP_W-1:0] tap_code;
  logic [MOD_W-1:0] frac_code;
  logic hi_sel;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dco_mod_tracker #(.TAP_W(TAP_W), .MOD_W(MOD_W)) i_dco_mod_tracker (
    .clk(clk), .rst_n(rst_n), .fll_en(fll_en), .step_up(step_up), .step_dn(step_dn),
    .load_en(load_en), .load_tap(load_tap), .load_frac(load_frac),
    .tap_code(tap_code), .frac_code(frac_code), .hi_sel(hi_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(input bit en, input bit up, input bit dn, input bit ld,
                       input int lt, input int lf);
    @(negedge clk);
    fll_en = en; step_up = up; step_dn = dn; load_en = ld;
    load_tap = TAP_W'(lt); load_frac = MOD_W'(lf);
    @(posedge clk);
    #1;
    step_up = 0; step_dn = 0; load_en = 0;
  endtask

  task automatic set_code(input int t, input int f);
    cycle(0, 0, 0, 1, t, f);
  endtask

  // R3: forbidden transition monitor
  logic [TAP_W-1:0] prev_tap;
  logic [MOD_W-1:0] prev_frac;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_frac == 5'd31 && tap_code == TAP_W'(prev_tap + 1) && frac_code == 5'd30) begin
        total++; bad++;
        $display("FAIL R3 bad shift actual=%0d/%0d expected=%0d/0", tap_code, frac_code, tap_code);
      end
    end
    prev_tap = tap_code;
    prev_frac = frac_code;
  end

  task automatic t_reset;
    chk(tap_code == 0, "R1 tap", tap_code, 0);
    chk(frac_code == 0, "R1 frac", frac_code, 0);
    chk(hi_sel == 0, "R1 sel", hi_sel, 0);
  endtask

  task automatic t_raise;
    set_code(2, 5);
    cycle(1, 1, 0, 0, 0, 0);
    chk(frac_code == 6 && tap_code == 2, "R2 inc", frac_code, 6);
    set_code(3, 31);
    cycle(1, 1, 0, 0, 0, 0);
    chk(tap_code == 4, "R3 tap", tap_code, 4);
    chk(frac_code == 0, "R3 frac", frac_code, 0);
  endtask

  task automatic t_lower;
    set_code(4, 9);
    cycle(1, 0, 1, 0, 0, 0);
    chk(frac_code == 8 && tap_code == 4, "R4 dec", frac_code, 8);
    set_code(4, 0);
    cycle(1, 0, 1, 0, 0, 0);
    chk(tap_code == 3, "R4 tap", tap_code, 3);
    chk(frac_code == 31, "R4 frac", frac_code, 31);
  endtask

  task automatic t_walk;
    set_code(0, 0);
    for (int i = 0; i < 256; i++) cycle(1, 1, 0, 0, 0, 0);
    chk(tap_code == 7 && frac_code == 31, "R5 top", tap_code * 32 + frac_code, 255);
    cycle(1, 1, 0, 0, 0, 0);
    chk(tap_code == 7 && frac_code == 31, "R5 top hold", tap_code * 32 + frac_code, 255);
    for (int i = 0; i < 256; i++) cycle(1, 0, 1, 0, 0, 0);
    chk(tap_code == 0 && frac_code == 0, "R5 bottom", tap_code * 32 + frac_code, 0);
  endtask

  task automatic t_cancel;
    set_code(5, 12);
    cycle(1, 1, 1, 0, 0, 0);
    chk(tap_code == 5 && frac_code == 12, "R6 cancel", tap_code * 32 + frac_code, 172);
  endtask

  task automatic t_disabled;
    set_code(6, 20);
    cycle(0, 1, 0, 0, 0, 0);
    chk(frac_code == 20 && tap_code == 6, "R7 up ignored", frac_code, 20);
    cycle(0, 0, 1, 0, 0, 0);
    chk(frac_code == 20 && tap_code == 6, "R7 dn ignored", frac_code, 20);
  endtask

  task automatic t_load;
    set_code(1, 17);
    chk(tap_code == 1 && frac_code == 17, "R8 load", tap_code * 32 + frac_code, 49);
    cycle(1, 0, 0, 1, 6, 3);
    chk(tap_code == 1 && frac_code == 17, "R8 load ignored", tap_code * 32 + frac_code, 49);
  endtask

  task automatic t_frame(input int m);
    int cnt = 0;
    set_code(2, m);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin
      cnt += hi_sel;
      cycle(0, 0, 0, 0, 0, 0);
    end
    chk(cnt == m, "R9 frame count", cnt, m);
  endtask

  task automatic t_half;
    logic last;
    set_code(0, 16);
    last = hi_sel;
    for (int i = 0; i < 8; i++) begin
      cycle(0, 0, 0, 0, 0, 0);
      chk(hi_sel == !last, "R10 alternate", hi_sel, !last);
      last = hi_sel;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_raise();
    t_lower();
    t_walk();
    t_cancel();
    t_disabled();
    t_load();
    t_frame(0);
    t_frame(1);
    t_frame(7);
    t_frame(16);
    t_frame(31);
    t_half();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule